// File: doc/BRIEF.md
# Selectable-Clock Event Counter Channel

This block is one counting channel that runs entirely on the master clock. It counts valid edges of a chosen counting clock. That clock is one of five internal prescaled clocks or one of three external clock inputs. The channel can count on the opposite edge of the chosen clock, and it can accept edges only while a gating input is high. External inputs are sampled by the master clock through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one before it. For this reason, each level of an external clock must last longer than one master clock period, and its frequency must stay at or below the master clock divided by 2.5.

The 16-bit count is always visible on an output and never has to be stopped to be read. When the count wraps past its top value, a sticky overflow flag is set. Reading the status clears that flag. A trigger input arms a reset of the count. The reset is applied on the next valid counting edge, not immediately.

Top module: `tmr_chan`

## Requirements
- R1: While `rst_n` is low, `count_o` is 0 and `ovf_o` is 0. Reset also clears the edge history, the prescaler and any pending trigger.
- R2: When `clk_sel_i` is 5, 6 or 7, the counting clock is `ext_clk_i[0]`, `ext_clk_i[1]` or `ext_clk_i[2]`. Each rising edge of the selected input raises `count_o` by one, visible three master clock cycles after the input changes. Edges on inputs that are not selected have no effect.
- R3: When `clk_sel_i` is 0, 1, 2, 3 or 4, the counting clock is internal with a period of 2, 8, 32, 128 or 1024 master cycles. The count rises by exactly one per period.
- R4: When `inv_i` is 1, the count advances on falling edges of the selected clock instead of rising edges.
- R5: `gate_sel_i` values 0, 1, 2 and 3 select no gating, `ext_clk_i[0]`, `ext_clk_i[1]` and `ext_clk_i[2]` respectively. With gating selected, an edge is counted only while the synchronized gate input is high.
- R6: A one-cycle pulse on `trig_i` leaves `count_o` unchanged until the next valid counting edge. On that edge the count becomes 0 instead of incrementing, and the edge after it gives 1.
- R7: When a valid edge moves the count from 0xFFFF to 0x0000, `ovf_o` becomes 1. It stays 1 while `stat_rd_i` is low.
- R8: `ovf_o` is the status read data. A cycle with `stat_rd_i` high clears it in the next cycle. If a wrap happens in that same cycle, the flag stays 1.
- R9: `count_o` shows the live count in every cycle, and counting continues while it is observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_clk_i | input | 3 | External clock and gate inputs, asynchronous |
| clk_sel_i | input | 3 | Counting clock select (0-4 internal, 5-7 external) |
| inv_i | input | 1 | Count on falling edges when 1 |
| gate_sel_i | input | 2 | Gate select (0 none, 1-3 external input 0-2) |
| trig_i | input | 1 | Arms a count reset for the next valid edge |
| stat_rd_i | input | 1 | Status read strobe; clears the overflow flag |
| count_o | output | 16 | Live count value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The status read and a counter wrap can fall in the same master cycle. Both try to change the overflow flag at once. The bench provokes this by running the fastest internal clock from reset until the count reads 0xFFFF. It then holds the read strobe across the two cycles up to and including the wrapping edge. The result is judged correct only if the flag reads 1 afterwards with the count at 0. A second, isolated read must then clear it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int NUM_INT = 5;
  localparam int NUM_EXT = 3;
  localparam int SEL_W   = 3;
  localparam int GATE_W  = 2;
  localparam int PRE_W   = 10;

  // prescaler bit that forms internal clock k (periods 2,8,32,128,1024)
  function automatic int int_tap(input int k);
    return (k < 4) ? 2 * k : 9;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int W = PRE_W,
  parameter int N = NUM_INT
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] lvl_o
);
  logic [W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_tap
    assign lvl_o[g] = div_q[int_tap(g)];
  end
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_lvl_i,
  input  logic [NUM_EXT-1:0] ext_lvl_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic               inv_i,
  input  logic [GATE_W-1:0]  gate_sel_i,
  output logic               edge_o
);
  localparam int NSRC = NUM_INT + NUM_EXT;

  logic [NSRC-1:0]      src_vec;
  logic [NUM_EXT:0]     gate_vec;
  logic                 lvl, gate_ok;
  logic                 prev_q, prev_d;

  always_comb begin
    src_vec  = {ext_lvl_i, int_lvl_i};
    gate_vec = {ext_lvl_i, 1'b1};
    lvl      = src_vec[clk_sel_i] ^ inv_i;
    gate_ok  = gate_vec[gate_sel_i];
    prev_d   = lvl;
    edge_o   = lvl & ~prev_q & gate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             trig_i,
  input  logic             stat_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d, ovf_q, ovf_d;
  logic             arm_now, wrap;

  always_comb begin
    arm_now = arm_q | trig_i;
    cnt_d   = cnt_q;
    arm_d   = arm_now;
    wrap    = 1'b0;
    if (edge_i) begin
      if (arm_now) begin
        cnt_d = '0;
        arm_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = &cnt_q;
      end
    end
    ovf_d = wrap | (ovf_q & ~stat_rd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
      ovf_q <= ovf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_clk_i,
  input  logic [SEL_W-1:0]   clk_sel_i,
  input  logic               inv_i,
  input  logic [GATE_W-1:0]  gate_sel_i,
  input  logic               trig_i,
  input  logic               stat_rd_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_o
);
  logic [NUM_INT-1:0] int_lvl;
  logic [NUM_EXT-1:0] ext_lvl;
  logic               cnt_edge;

  tmr_prescale u_pre (.clk(clk), .rst_n(rst_n), .lvl_o(int_lvl));

  tmr_sync #(.W(NUM_EXT)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .sync_o(ext_lvl));

  tmr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .int_lvl_i(int_lvl), .ext_lvl_i(ext_lvl),
    .clk_sel_i(clk_sel_i), .inv_i(inv_i), .gate_sel_i(gate_sel_i),
    .edge_o(cnt_edge));

  tmr_core u_core (
    .clk(clk), .rst_n(rst_n), .edge_i(cnt_edge), .trig_i(trig_i),
    .stat_rd_i(stat_rd_i), .count_o(count_o), .ovf_o(ovf_o));
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd_i,
  input logic             cnt_edge,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |->
      ((count_o == $past(count_o) + 1'b1) || (count_o == '0)));

  // R6
  cnt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> $past(cnt_edge));

  // R7
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ((count_o == '0) && ($past(count_o) == '1)));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !stat_rd_i) |=> ovf_o);

  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> $past(stat_rd_i));
endmodule

bind tmr_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd_i(stat_rd_i), .cnt_edge(cnt_edge),
  .count_o(count_o), .ovf_o(ovf_o));

// File: tb/tmr_chan_test.sv
`timescale 1ns/1ps
module tmr_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext = '0;
  logic [2:0]  sel = 3'd5;
  logic        inv = 1'b0;
  logic [1:0]  gsel = '0;
  logic        trig = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] count;
  logic        ovf;
  int          checks = 0, fails = 0;
  int          exp_cnt = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  tmr_chan uut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext), .clk_sel_i(sel), .inv_i(inv),
    .gate_sel_i(gsel), .trig_i(trig), .stat_rd_i(rd), .count_o(count),
    .ovf_o(ovf));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic pulse(input int idx);
    ext[idx] = 1'b1; wait_n(4);
    ext[idx] = 1'b0; wait_n(4);
  endtask

  initial begin
    wait_n(3);
    check("R1 count", count, 0);
    check("R1 ovf", ovf, 0);
    rst_n = 1'b1;
    wait_n(2);

    // R2: each external source, with unselected inputs ignored
    for (int s = 0; s < 3; s++) begin
      sel = 3'(5 + s);
      wait_n(2);
      for (int p = 0; p < 3 + s; p++) pulse(s);
      exp_cnt += 3 + s;
      pulse((s + 1) % 3);
      pulse((s + 2) % 3);
      check("R2 ext count", count, exp_cnt);
    end

    // R2 latency: visible on the third cycle after the input rises
    sel = 3'd5;
    ext[0] = 1'b1; wait_n(2);
    check("R2 before latency", count, exp_cnt);
    wait_n(1);
    exp_cnt++;
    check("R2 at latency", count, exp_cnt);
    wait_n(2);

    // R4: invert while high, then count on falling edges only
    inv = 1'b1; wait_n(4);
    check("R4 no count on invert", count, exp_cnt);
    ext[0] = 1'b0; wait_n(4);
    exp_cnt++;
    check("R4 falling edge", count, exp_cnt);
    ext[0] = 1'b1; wait_n(4);
    check("R4 rising ignored", count, exp_cnt);
    ext[0] = 1'b0; wait_n(4);
    exp_cnt++;
    for (int p = 0; p < 3; p++) pulse(0);
    exp_cnt += 3;
    check("R4 falling sweep", count, exp_cnt);
    inv = 1'b0; wait_n(4);
    check("R4 restore", count, exp_cnt);

    // R5: clock ext2, gate by ext0 and ext1
    sel = 3'd7;
    for (int g = 1; g <= 2; g++) begin
      gsel = 2'(g);
      wait_n(2);
      for (int p = 0; p < 3; p++) pulse(2);
      check("R5 gate closed", count, exp_cnt);
      ext[g-1] = 1'b1; wait_n(4);
      for (int p = 0; p < 2 + g; p++) pulse(2);
      exp_cnt += 2 + g;
      check("R5 gate open", count, exp_cnt);
      ext[g-1] = 1'b0; wait_n(4);
    end
    gsel = 2'd0;

    // R6: trigger waits for the next valid edge
    sel = 3'd5; wait_n(2);
    trig = 1'b1; wait_n(1); trig = 1'b0;
    wait_n(6);
    check("R6 held after trigger", count, exp_cnt);
    pulse(0);
    check("R6 zero on edge", count, 0);
    pulse(0);
    check("R6 counts again", count, 1);

    // R3 / R9: internal periods, measured live
    for (int i = 0; i < 5; i++) begin
      int per, k, c0;
      per = (i < 4) ? (2 << (2 * i)) : 1024;
      k   = (i < 4) ? 4 : 2;
      sel = 3'(i);
      wait_n(2 * per);
      c0 = count;
      wait_n(per * k);
      check("R3 R9 internal period", int'(16'(count - 16'(c0))), k);
    end

    // R7 / R8: wrap from reset on the period-2 clock
    rst_n = 1'b0; wait_n(2);
    sel = 3'd0;
    rst_n = 1'b1;
    while (count != 16'hFFFF) wait_n(1);
    check("R7 no flag before wrap", ovf, 0);
    rd = 1'b1; wait_n(2); rd = 1'b0;
    check("R7 wrap to zero", count, 0);
    check("R8 set wins over read", ovf, 1);
    wait_n(5);
    check("R7 sticky", ovf, 1);
    rd = 1'b1; wait_n(1); rd = 1'b0;
    check("R8 read clears", ovf, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule